// File: doc/BRIEF.md
# Power-Management Task/Event Register Block

This block is the software-visible control face of a power-management peripheral. It provides two trigger-only tasks and three event flags on a simple 32-bit register bus. The bus has an address, a write enable, write data and a combinational read-data return.

Each task can be started in two ways. Software can write a 1 to the task's register, or the block can subscribe the task to one line of a channel bus. The tasks request constant-latency operation and low-power operation.

Each event flag is set by a one-cycle pulse from the power logic. The three events are a supply warning, a sleep entry and a sleep exit. Each flag can be published as a one-cycle pulse onto a chosen channel-bus line. Each flag can also raise the shared interrupt line.

A single interrupt-enable register gates the interrupt. It can be reached at three addresses: one for a plain write, one where written ones set bits, and one where written ones clear bits.

Top module: `pm_task_event_regs`

## Requirements
- R1: After reset every readable register returns 0, and `task_pulse_o`, `chan_out_o` and `irq_o` are 0.
- R2: A write whose data has bit 0 set, to offset 0x78 (task 0) or 0x7C (task 1), drives `task_pulse_o[0]` or `task_pulse_o[1]` high for exactly the cycle after the write. Writing bit 0 as 0 gives no pulse. Reading either task offset returns 0.
- R3: The subscribe registers sit at 0xF8 (task 0) and 0xFC (task 1). Each holds a channel index in bits [7:0] and an enable in bit 31, and its other bits read 0. When the enable is 1 and `chan_in_i[index]` is high at a clock edge, the task pulses in the next cycle.
- R4: A subscription whose enable is 0 never fires its task. An enabled subscription ignores every channel except the one its index names.
- R5: A pulse on `evt_pulse_i[k]` makes the flag for event k read 1 from the next cycle on. Event k is read at 0x108 for k=0, 0x114 for k=1 and 0x118 for k=2. A software write to a flag stores data bit 0, so writing 0 clears the flag.
- R6: When a hardware pulse and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R7: The publish registers sit at 0x188, 0x194 and 0x198, one for each of events 0, 1 and 2. Each has the same layout as a subscribe register. When an event pulses and its publish enable is 1, `chan_out_o[index]` is high for exactly the next cycle. Pulses from several events are ORed. Nothing is published when the enable is 0 or when software sets the flag itself.
- R8: The interrupt enable at 0x300 is read/write. Bit 2 enables event 0, bit 5 enables event 1 and bit 6 enables event 2. All other bits read 0.
- R9: At 0x304, written ones set enable bits. At 0x308, written ones clear enable bits. Zeros written to either address leave the enables unchanged. Reading 0x300, 0x304 or 0x308 returns the current enables.
- R10: `irq_o` is a level. It is high exactly when some event's flag and its enable bit are both 1, and it falls only when the flag or the enable is cleared.
- R11: A read from any address that is not mapped returns 0. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe, one access per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address, combinational |
| evt_pulse_i | input | 3 | Hardware event pulses: supply warning, sleep entry, sleep exit |
| task_pulse_o | output | 2 | Task pulses: constant latency, low power |
| chan_in_i | input | 2**CHAN_W | Channel bus into the block, used by subscriptions |
| chan_out_o | output | 2**CHAN_W | Channel bus out of the block, driven by publications |
| irq_o | output | 1 | Level interrupt |

## Verification
Every state change takes effect at the clock edge that samples the write, event pulse or channel line. This applies to flags, enables, configuration, task pulses and published pulses. The result therefore appears one cycle after the stimulus. `bus_rdata_o` and `irq_o` follow that state combinationally in the same cycle. The bench drives its inputs just after the falling edge. A behavioural model advances on each rising edge. Outputs and read data are compared with the model on every falling edge, which is half a cycle after the edge that was due to change them. A delay or an early response shows up as a mismatch on that edge.

// File: rtl/pm_te_pkg.sv
package pm_te_pkg;
  localparam int NUM_TASK = 2;
  localparam int NUM_EVT  = 3;
  localparam int OFF_W    = 12;

  localparam logic [OFF_W-1:0] TASK_BASE = 12'h078;
  localparam logic [OFF_W-1:0] CFG_SHIFT = 12'h080;  // subscribe/publish sit 0x80 above their task/event
  localparam logic [OFF_W-1:0] EVT_BASE  = 12'h100;
  localparam logic [NUM_EVT-1:0][OFF_W-1:0] EVT_OFF = {12'h118, 12'h114, 12'h108};
  localparam logic [OFF_W-1:0] IEN_DIR   = 12'h300;
  localparam logic [OFF_W-1:0] IEN_SET   = 12'h304;
  localparam logic [OFF_W-1:0] IEN_CLR   = 12'h308;

  function automatic logic [OFF_W-1:0] task_off(input int t);
    return TASK_BASE + OFF_W'(4 * t);
  endfunction

  function automatic logic [OFF_W-1:0] sub_off(input int t);
    return task_off(t) + CFG_SHIFT;
  endfunction

  function automatic logic [OFF_W-1:0] pub_off(input int e);
    return EVT_OFF[e] + CFG_SHIFT;
  endfunction

  // enable bit position follows the event's word offset above EVT_BASE
  function automatic int irq_bit(input int e);
    return int'((EVT_OFF[e] - EVT_BASE) >> 2);
  endfunction

  function automatic logic [31:0] ien_mask();
    logic [31:0] m;
    m = '0;
    for (int e = 0; e < NUM_EVT; e++) m[irq_bit(e)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pm_chan_cfg.sv
module pm_chan_cfg #(
  parameter int CHAN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              en_d_i,
  input  logic [CHAN_W-1:0] idx_d_i,
  output logic              en_o,
  output logic [CHAN_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      idx_o <= '0;
    end else if (wr_i) begin
      en_o  <= en_d_i;
      idx_o <= idx_d_i;
    end
  end

  a_r3_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(en_o) && $stable(idx_o)));
endmodule

// File: rtl/pm_task_unit.sv
module pm_task_unit #(
  parameter int CHAN_W = 8,
  localparam int NUM_CH = 1 << CHAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_fire_i,
  input  logic              sub_en_i,
  input  logic [CHAN_W-1:0] sub_idx_i,
  input  logic [NUM_CH-1:0] chan_in_i,
  output logic              pulse_o
);
  logic sub_hit;
  assign sub_hit = sub_en_i && chan_in_i[sub_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= sw_fire_i || sub_hit;
  end

  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_fire_i || sub_hit) |=> !pulse_o);
  a_r2_sw_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_fire_i |=> pulse_o);
endmodule

// File: rtl/pm_event_unit.sv
module pm_event_unit #(
  parameter int CHAN_W = 8,
  localparam int NUM_CH = 1 << CHAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_i,
  input  logic              sw_we_i,
  input  logic              sw_d_i,
  input  logic              pub_en_i,
  input  logic [CHAN_W-1:0] pub_idx_i,
  output logic              flag_o,
  output logic [NUM_CH-1:0] chan_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (hw_i)    flag_o <= 1'b1;  // hardware beats software clear
    else if (sw_we_i) flag_o <= sw_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_o <= '0;
    else begin
      chan_o <= '0;
      if (hw_i && pub_en_i) chan_o[pub_idx_i] <= 1'b1;
    end
  end

  a_r6_hw_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_i |=> flag_o);
  a_r5_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_i && !sw_we_i) |=> $stable(flag_o));
  a_r7_pub_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chan_o) |-> $past(hw_i && pub_en_i));
endmodule

// File: rtl/pm_task_event_regs.sv
module pm_task_event_regs
  import pm_te_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CHAN_W = 8,
  localparam int NUM_CH = 1 << CHAN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [NUM_EVT-1:0]  evt_pulse_i,
  output logic [NUM_TASK-1:0] task_pulse_o,
  input  logic [NUM_CH-1:0]   chan_in_i,
  output logic [NUM_CH-1:0]   chan_out_o,
  output logic                irq_o
);
  localparam logic [31:0] IEN_MASK = ien_mask();

  logic [NUM_TASK-1:0]             sub_en;
  logic [NUM_TASK-1:0][CHAN_W-1:0] sub_idx;
  logic [NUM_EVT-1:0]              pub_en;
  logic [NUM_EVT-1:0][CHAN_W-1:0]  pub_idx;
  logic [NUM_EVT-1:0]              flag;
  logic [NUM_EVT-1:0][NUM_CH-1:0]  evt_chan;
  logic [NUM_EVT-1:0]              irq_term;
  logic [31:0]                     ien_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [OFF_W-1:0] off);
    return a == ADDR_W'(off);
  endfunction

  for (genvar t = 0; t < NUM_TASK; t++) begin : g_task
    pm_chan_cfg #(.CHAN_W(CHAN_W)) u_sub (
      .clk_i, .rst_ni,
      .wr_i   (bus_we_i && hit(bus_addr_i, sub_off(t))),
      .en_d_i (bus_wdata_i[31]),
      .idx_d_i(bus_wdata_i[CHAN_W-1:0]),
      .en_o   (sub_en[t]),
      .idx_o  (sub_idx[t])
    );
    pm_task_unit #(.CHAN_W(CHAN_W)) u_task (
      .clk_i, .rst_ni,
      .sw_fire_i(bus_we_i && hit(bus_addr_i, task_off(t)) && bus_wdata_i[0]),
      .sub_en_i (sub_en[t]),
      .sub_idx_i(sub_idx[t]),
      .chan_in_i,
      .pulse_o  (task_pulse_o[t])
    );
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    localparam int IB = irq_bit(e);
    pm_chan_cfg #(.CHAN_W(CHAN_W)) u_pub (
      .clk_i, .rst_ni,
      .wr_i   (bus_we_i && hit(bus_addr_i, pub_off(e))),
      .en_d_i (bus_wdata_i[31]),
      .idx_d_i(bus_wdata_i[CHAN_W-1:0]),
      .en_o   (pub_en[e]),
      .idx_o  (pub_idx[e])
    );
    pm_event_unit #(.CHAN_W(CHAN_W)) u_evt (
      .clk_i, .rst_ni,
      .hw_i     (evt_pulse_i[e]),
      .sw_we_i  (bus_we_i && hit(bus_addr_i, EVT_OFF[e])),
      .sw_d_i   (bus_wdata_i[0]),
      .pub_en_i (pub_en[e]),
      .pub_idx_i(pub_idx[e]),
      .flag_o   (flag[e]),
      .chan_o   (evt_chan[e])
    );
    assign irq_term[e] = flag[e] && ien_q[IB];
  end

  always_comb begin
    chan_out_o = '0;
    for (int e = 0; e < NUM_EVT; e++) chan_out_o |= evt_chan[e];
  end

  assign irq_o = |irq_term;

  // one enable store, three aliases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ien_q <= '0;
    else if (bus_we_i) begin
      if (hit(bus_addr_i, IEN_DIR))      ien_q <= bus_wdata_i & IEN_MASK;
      else if (hit(bus_addr_i, IEN_SET)) ien_q <= ien_q | (bus_wdata_i & IEN_MASK);
      else if (hit(bus_addr_i, IEN_CLR)) ien_q <= ien_q & ~bus_wdata_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit(bus_addr_i, IEN_DIR) || hit(bus_addr_i, IEN_SET) || hit(bus_addr_i, IEN_CLR))
      bus_rdata_o = ien_q;
    for (int t = 0; t < NUM_TASK; t++)
      if (hit(bus_addr_i, sub_off(t))) begin
        bus_rdata_o[31]         = sub_en[t];
        bus_rdata_o[CHAN_W-1:0] = sub_idx[t];
      end
    for (int e = 0; e < NUM_EVT; e++) begin
      if (hit(bus_addr_i, EVT_OFF[e])) bus_rdata_o[0] = flag[e];
      if (hit(bus_addr_i, pub_off(e))) begin
        bus_rdata_o[31]         = pub_en[e];
        bus_rdata_o[CHAN_W-1:0] = pub_idx[e];
      end
    end
  end

  a_r8_ien_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q & ~IEN_MASK) == '0);
  a_r9_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && hit(bus_addr_i, IEN_SET)) |=>
      ((ien_q & $past(bus_wdata_i & IEN_MASK)) == $past(bus_wdata_i & IEN_MASK)));
  a_r9_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && hit(bus_addr_i, IEN_CLR)) |=> ((ien_q & $past(bus_wdata_i)) == '0));
  a_r10_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|flag));
endmodule

// File: tb/pm_task_event_regs_bench.sv
module pm_task_event_regs_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [11:0]  bus_addr_i = '0;
  logic         bus_we_i = 1'b0;
  logic [31:0]  bus_wdata_i = '0;
  logic [31:0]  bus_rdata_o;
  logic [2:0]   evt_pulse_i = '0;
  logic [1:0]   task_pulse_o;
  logic [255:0] chan_in_i = '0;
  logic [255:0] chan_out_o;
  logic         irq_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #10 clk_i = ~clk_i;

  pm_task_event_regs u_pm_task_event_regs (.*);

  // behavioural reference state
  int           m_task [2];
  int           m_sub_en [2];
  int           m_sub_idx [2];
  int           m_flag [3];
  int           m_pub_en [3];
  int           m_pub_idx [3];
  logic [255:0] m_chan = '0;
  logic [31:0]  m_ien = '0;

  initial begin
    foreach (m_task[i]) begin m_task[i] = 0; m_sub_en[i] = 0; m_sub_idx[i] = 0; end
    foreach (m_flag[i]) begin m_flag[i] = 0; m_pub_en[i] = 0; m_pub_idx[i] = 0; end
  end

  function automatic int evt_addr(int e);
    case (e) 0: return 'h108; 1: return 'h114; default: return 'h118; endcase
  endfunction

  function automatic int ien_bit(int e);
    case (e) 0: return 2; 1: return 5; default: return 6; endcase
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    logic [31:0] r = '0;
    if (a == 'h300 || a == 'h304 || a == 'h308) r = m_ien;
    for (int t = 0; t < 2; t++)
      if (a == 'hF8 + 4*t) r = {m_sub_en[t][0], 23'd0, 8'(m_sub_idx[t])};
    for (int e = 0; e < 3; e++) begin
      if (a == evt_addr(e)) r = 32'(m_flag[e]);
      if (a == evt_addr(e) + 'h80) r = {m_pub_en[e][0], 23'd0, 8'(m_pub_idx[e])};
    end
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 2; i++) begin m_task[i] = 0; m_sub_en[i] = 0; m_sub_idx[i] = 0; end
      for (int i = 0; i < 3; i++) begin m_flag[i] = 0; m_pub_en[i] = 0; m_pub_idx[i] = 0; end
      m_chan = '0;
      m_ien  = '0;
    end else begin
      int a;
      a = int'(bus_addr_i);
      for (int t = 0; t < 2; t++)
        m_task[t] = ((bus_we_i && a == 'h78 + 4*t && bus_wdata_i[0]) ||
                     (m_sub_en[t] != 0 && chan_in_i[m_sub_idx[t]])) ? 1 : 0;
      m_chan = '0;
      for (int e = 0; e < 3; e++)
        if (evt_pulse_i[e] && m_pub_en[e] != 0) m_chan[m_pub_idx[e]] = 1'b1;
      for (int e = 0; e < 3; e++) begin
        if (evt_pulse_i[e]) m_flag[e] = 1;
        else if (bus_we_i && a == evt_addr(e)) m_flag[e] = int'(bus_wdata_i[0]);
      end
      if (bus_we_i) begin
        for (int t = 0; t < 2; t++)
          if (a == 'hF8 + 4*t) begin m_sub_en[t] = int'(bus_wdata_i[31]); m_sub_idx[t] = int'(bus_wdata_i[7:0]); end
        for (int e = 0; e < 3; e++)
          if (a == evt_addr(e) + 'h80) begin m_pub_en[e] = int'(bus_wdata_i[31]); m_pub_idx[e] = int'(bus_wdata_i[7:0]); end
        if (a == 'h300) m_ien = bus_wdata_i & 32'h64;
        if (a == 'h304) m_ien = m_ien | (bus_wdata_i & 32'h64);
        if (a == 'h308) m_ien = m_ien & ~bus_wdata_i;
      end
    end
  end

  task automatic cmp(string tag, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // compare half a cycle after each rising edge
  always @(negedge clk_i) if (!done) begin
    logic [1:0] et;
    logic       ei;
    et = {m_task[1][0], m_task[0][0]};
    ei = 1'b0;
    for (int e = 0; e < 3; e++) ei |= (m_flag[e] != 0) && m_ien[ien_bit(e)];
    cmp("R2 R3 R4 task_pulse_o", 256'(task_pulse_o), 256'(et));
    cmp("R7 chan_out_o", chan_out_o, m_chan);
    cmp("R10 irq_o", 256'(irq_o), 256'(ei));
    cmp("R1 R3 R5 R6 R8 R9 R11 bus_rdata_o", 256'(bus_rdata_o), 256'(exp_rd(int'(bus_addr_i))));
  end

  task automatic drive(int a, bit we, logic [31:0] d, logic [2:0] ev, logic [255:0] ch);
    @(negedge clk_i); #1;
    bus_addr_i = 12'(a); bus_we_i = we; bus_wdata_i = d; evt_pulse_i = ev; chan_in_i = ch;
  endtask
  task automatic wr(int a, logic [31:0] d); drive(a, 1, d, '0, '0); endtask
  task automatic rd(int a); drive(a, 0, '0, '0, '0); endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int addrs [16] = '{'h78, 'h7C, 'hF8, 'hFC, 'h108, 'h114, 'h118, 'h188,
                       'h194, 'h198, 'h300, 'h304, 'h308, 'h10C, 'h000, 'h30C};
    rd('h300); rd('h108); rd('hF8);
    rst_ni = 1'b1;
    // R1: reset values read back on every mapped register
    for (int i = 0; i < 16; i++) rd(addrs[i]);
    // R2: software task triggers
    wr('h78, 1); rd('h78); wr('h7C, 32'hFFFF_FFFF); wr('h7C, 0); rd('h7C);
    // R3 and R4: subscriptions
    wr('hF8, 32'h8000_0005); rd('hF8);
    drive('hF8, 0, 0, 0, 256'(1) << 5); rd('hF8);
    drive(0, 0, 0, 0, 256'(1) << 6); rd(0);
    wr('hFC, 32'h0000_0009); drive('hFC, 0, 0, 0, 256'(1) << 9); rd('hFC);
    wr('hFC, 32'hFFFF_FF09); rd('hFC); drive(0, 0, 0, 0, 256'(1) << 9); rd(0);
    // R7: publication, shared channel ORed, disabled event silent
    wr('h188, 32'h8000_0010); wr('h194, 32'h8000_0010); wr('h198, 32'h0000_0011);
    drive(0, 0, 0, 3'b111, '0); rd('h108); rd('h114); rd('h118);
    // R5: software clear and software set without publish
    wr('h114, 0); rd('h114); wr('h198, 32'h8000_0022); wr('h118, 0); wr('h118, 1); rd('h118);
    // R6: hardware set against software clear in the same cycle
    drive('h108, 1, 0, 3'b001, '0); rd('h108);
    // R8, R9, R10: enable aliases and interrupt level
    wr('h300, 32'hFFFF_FFFF); rd('h300); rd('h304); rd('h308);
    wr('h308, 32'h20); rd('h300); wr('h304, 0); rd('h304);
    wr('h108, 0); rd('h300); wr('h118, 0); wr('h304, 32'h24); rd('h308);
    wr('h300, 0); drive(0, 0, 0, 3'b010, '0); wr('h304, 32'h20); wr('h114, 0); rd('h114);
    // R11: unmapped addresses
    wr('h10C, 32'hFFFF_FFFF); rd('h10C); rd('h30C); rd('h104); rd('h000);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [255:0] ch;
      d = {1'($urandom), 23'($urandom), 8'($urandom % 8)};
      ch = '0;
      if ($urandom % 3 == 0) ch[$urandom % 8] = 1'b1;
      drive(addrs[$urandom % 16], ($urandom % 2) == 1, d,
            ($urandom % 4 == 0) ? 3'($urandom) : 3'b000, ch);
    end
    rd(0); rd(0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule